// File: doc/BRIEF.md
# Load-Use Stall Controller

This block finds the one data dependence that forwarding cannot cover in a five-stage in-order pipeline. The case is a load in execute whose destination register is read by the instruction now in decode. In the cycle it sees that case, the block holds the program counter and the fetch/decode register so that the dependent instruction is decoded again. It also replaces the control word entering the decode/execute register with all zeros, so one no-op moves down the pipe behind the load. The load, and everything ahead of it, keeps moving. One cycle later the loaded value can be forwarded, so each load-use pair costs exactly one cycle.

The block includes a thin pipeline shell so that the stall can be seen over time. The shell holds the PC, the fetch/decode instruction register, and the decode/execute control word and destination field. The main decoder sits outside the block. It returns a control word for the instruction in fetch/decode. Instruction fetch also sits outside the block and returns the word addressed by the PC.

Top module: `lduse_stall_pipe`

## Requirements
- R1: While `rstN` is low, `pc`, `ifIdInstr`, `idExCtrl` and `idExRt` are zero, and `pcWrite` and `ifIdWrite` are 1.
- R2: A hazard is detected when all three of these hold:
  - bit 5 of `idExCtrl` (the memory-read flag) is 1;
  - `idExRt` is nonzero;
  - `idExRt` equals the first source field `ifIdInstr[25:21]` or the second source field `ifIdInstr[20:16]`.
  When a hazard is detected, `pcWrite` and `ifIdWrite` are 0 in that same cycle.
- R3: In a cycle with a detected hazard, `pc` and `ifIdInstr` keep their values across the next clock edge.
- R4: The clock edge that follows a detected hazard loads an all-zero control word into `idExCtrl`. The held instruction enters decode/execute one edge later.
- R5: Each load-use pair costs exactly one stall cycle, and the write enables go back to 1 in the next cycle. A load whose user is itself a load, followed by a user of that second load, stalls once for each pair.
- R6: There is no stall when the load's destination is register 0, when the decoding instruction reads neither of the load's registers, or when the instruction in execute is not a load.
- R7: Without a stall, each edge does four things:
  - adds 4 to `pc`;
  - loads `fetchInstr` into `ifIdInstr`;
  - loads `decCtrl` into `idExCtrl`;
  - loads `ifIdInstr[20:16]` into `idExRt`.
- R8: Two loads in a row, where the second reads neither register of the first, pass through without any bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchInstr | input | 32 | Instruction word fetched at `pc` |
| decCtrl | input | 9 | Control word from the main decoder for `ifIdInstr` |
| pc | output | 32 | Program counter |
| ifIdInstr | output | 32 | Instruction held in fetch/decode |
| idExCtrl | output | 9 | Control word latched into decode/execute |
| idExRt | output | 5 | Destination field latched into decode/execute |
| pcWrite | output | 1 | PC write enable, active high |
| ifIdWrite | output | 1 | Fetch/decode write enable, active high |

## Verification
A wrong hazard decision shows at the write-enable ports in the same cycle, because the detection is purely combinational on registered state. A missed or spurious stall shows in `pc` and `ifIdInstr` one edge later, as a repeated or skipped address. A bubble that carries a nonzero control word shows in `idExCtrl` one edge after detection. A repeated bubble shows as a second held PC two edges after the first.

// File: rtl/lduse_pkg.sv
package lduse_pkg;
  // Strobes from hazard control to the pipeline registers
  typedef struct packed {
    logic pcWrite;
    logic ifIdWrite;
    logic bubble;
  } strobe_t;
endpackage

// File: rtl/lduse_ctrl.sv
module lduse_ctrl
  import lduse_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int REG_W   = 5,
  parameter int RS_LSB  = 21,
  parameter int RT_LSB  = 16
) (
  input  logic               idExMemRead,
  input  logic [REG_W-1:0]   idExRt,
  input  logic [INSTR_W-1:0] ifIdInstr,
  output strobe_t            strobes
);
  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0] srcMatch;
  logic               destLive;
  logic               hazard;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam int LSB = (g == 0) ? RS_LSB : RT_LSB;
    assign srcMatch[g] = (ifIdInstr[LSB +: REG_W] == idExRt);
  end

  assign destLive = (idExRt != '0);
  assign hazard   = idExMemRead && destLive && (|srcMatch);

  always_comb begin
    strobes.pcWrite   = !hazard;
    strobes.ifIdWrite = !hazard;
    strobes.bubble    = hazard;
  end
endmodule

// File: rtl/lduse_dpath.sv
module lduse_dpath
  import lduse_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4,
  parameter int INSTR_W = 32,
  parameter int CTRL_W  = 9,
  parameter int REG_W   = 5,
  parameter int RT_LSB  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobes,
  input  logic [INSTR_W-1:0] fetchInstr,
  input  logic [CTRL_W-1:0]  decCtrl,
  output logic [PC_W-1:0]    pc,
  output logic [INSTR_W-1:0] ifIdInstr,
  output logic [CTRL_W-1:0]  idExCtrl,
  output logic [REG_W-1:0]   idExRt
);
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  logic [CTRL_W-1:0] ctrlMuxed;

  assign ctrlMuxed = strobes.bubble ? '0 : decCtrl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc        <= '0;
      ifIdInstr <= '0;
    end else begin
      if (strobes.pcWrite)   pc        <= pc + STEP;
      if (strobes.ifIdWrite) ifIdInstr <= fetchInstr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idExCtrl <= '0;
      idExRt   <= '0;
    end else begin
      idExCtrl <= ctrlMuxed;
      idExRt   <= ifIdInstr[RT_LSB +: REG_W];
    end
  end
endmodule

// File: rtl/lduse_stall_pipe.sv
module lduse_stall_pipe
  import lduse_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int PC_STEP     = 4,
  parameter int INSTR_W     = 32,
  parameter int CTRL_W      = 9,
  parameter int REG_W       = 5,
  parameter int RS_LSB      = 21,
  parameter int RT_LSB      = 16,
  parameter int MEMREAD_BIT = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] fetchInstr,
  input  logic [CTRL_W-1:0]  decCtrl,
  output logic [PC_W-1:0]    pc,
  output logic [INSTR_W-1:0] ifIdInstr,
  output logic [CTRL_W-1:0]  idExCtrl,
  output logic [REG_W-1:0]   idExRt,
  output logic               pcWrite,
  output logic               ifIdWrite
);
  strobe_t strobes;

  lduse_ctrl #(
    .INSTR_W(INSTR_W), .REG_W(REG_W), .RS_LSB(RS_LSB), .RT_LSB(RT_LSB)
  ) u_ctrl (
    .idExMemRead(idExCtrl[MEMREAD_BIT]),
    .idExRt     (idExRt),
    .ifIdInstr  (ifIdInstr),
    .strobes    (strobes)
  );

  lduse_dpath #(
    .PC_W(PC_W), .PC_STEP(PC_STEP), .INSTR_W(INSTR_W), .CTRL_W(CTRL_W),
    .REG_W(REG_W), .RT_LSB(RT_LSB)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .fetchInstr(fetchInstr),
    .decCtrl   (decCtrl),
    .pc        (pc),
    .ifIdInstr (ifIdInstr),
    .idExCtrl  (idExCtrl),
    .idExRt    (idExRt)
  );

  assign pcWrite   = strobes.pcWrite;
  assign ifIdWrite = strobes.ifIdWrite;
endmodule

// File: rtl/lduse_stall_chk.sv
module lduse_stall_chk #(
  parameter int PC_W        = 32,
  parameter int PC_STEP     = 4,
  parameter int INSTR_W     = 32,
  parameter int CTRL_W      = 9,
  parameter int MEMREAD_BIT = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic [PC_W-1:0]    pc,
  input logic [INSTR_W-1:0] ifIdInstr,
  input logic [CTRL_W-1:0]  idExCtrl,
  input logic               pcWrite,
  input logic               ifIdWrite
);
  assert_pc_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !pcWrite |=> (pc == $past(pc)));

  assert_ifid_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !ifIdWrite |=> (ifIdInstr == $past(ifIdInstr)));

  assert_bubble_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    !pcWrite |=> (idExCtrl == '0));

  assert_single_stall_R5: assert property (@(posedge clk) disable iff (!rstN)
    !pcWrite |=> pcWrite);

  assert_no_load_no_stall_R6: assert property (@(posedge clk) disable iff (!rstN)
    !idExCtrl[MEMREAD_BIT] |-> (pcWrite && ifIdWrite));

  assert_pc_advance_R7: assert property (@(posedge clk) disable iff (!rstN)
    pcWrite |=> (pc == $past(pc) + PC_W'(PC_STEP)));
endmodule

bind lduse_stall_pipe lduse_stall_chk #(
  .PC_W(PC_W), .PC_STEP(PC_STEP), .INSTR_W(INSTR_W), .CTRL_W(CTRL_W),
  .MEMREAD_BIT(MEMREAD_BIT)
) u_chk (
  .clk(clk), .rstN(rstN), .pc(pc), .ifIdInstr(ifIdInstr),
  .idExCtrl(idExCtrl), .pcWrite(pcWrite), .ifIdWrite(ifIdWrite)
);

// File: tb/test_lduse_stall_pipe.sv
module test_lduse_stall_pipe;
  localparam logic [8:0] LOAD_CTRL = 9'h0AB; // memory-read flag in bit 5 set
  localparam logic [8:0] ALU_CTRL  = 9'h141; // bit 5 clear
  localparam int NEDGE = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] fetchInstr;
  logic [8:0]  decCtrl;
  logic [31:0] pc;
  logic [31:0] ifIdInstr;
  logic [8:0]  idExCtrl;
  logic [4:0]  idExRt;
  logic        pcWrite;
  logic        ifIdWrite;

  logic [31:0] prog [8];
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [8:0] decode(input logic [31:0] w);
    if (w == 32'h0)           return 9'h0;
    if (w[31:26] == 6'h23)    return LOAD_CTRL;
    return ALU_CTRL;
  endfunction

  function automatic logic [31:0] mkLoad(input int base, input int dst);
    return {6'h23, 5'(base), 5'(dst), 16'h0004};
  endfunction

  function automatic logic [31:0] mkAlu(input int a, input int b);
    return {6'h00, 5'(a), 5'(b), 5'd9, 5'd0, 6'h20};
  endfunction

  assign fetchInstr = (pc[31:5] == '0) ? prog[pc[4:2]] : 32'h0;
  assign decCtrl    = decode(ifIdInstr);

  lduse_stall_pipe i_lduse_stall_pipe (
    .clk(clk), .rstN(rstN), .fetchInstr(fetchInstr), .decCtrl(decCtrl),
    .pc(pc), .ifIdInstr(ifIdInstr), .idExCtrl(idExCtrl), .idExRt(idExRt),
    .pcWrite(pcWrite), .ifIdWrite(ifIdWrite)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reset, then step NEDGE edges comparing against an arithmetic trace.
  // stallAt[k] = 1 means a hazard is expected after edge k.
  task automatic runCase(input string req, input logic [NEDGE:0] stallAt);
    int held = 0;
    logic [31:0] prevIfId = 32'h0;
    bit prevStall = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check({req, " R1 pc"}, pc, 32'h0);
    check({req, " R1 ctrl"}, {23'h0, idExCtrl}, 32'h0);
    check({req, " R1 enables"}, {30'h0, pcWrite, ifIdWrite}, 32'h3);
    rstN = 1'b1;
    for (int k = 1; k <= NEDGE; k++) begin
      logic [31:0] expIfId;
      @(negedge clk);
      expIfId = prog[k - 1 - held];
      check({req, " R3/R7 pc"}, pc, 32'(4 * (k - held)));
      check({req, " R3/R7 ifId"}, ifIdInstr, expIfId);
      check({req, " R4/R7 ctrl"}, {23'h0, idExCtrl},
            {23'h0, (prevStall ? 9'h0 : decode(prevIfId))});
      check({req, " R7 rt"}, {27'h0, idExRt}, {27'h0, prevIfId[20:16]});
      check({req, " R2/R5 enables"}, {30'h0, pcWrite, ifIdWrite},
            stallAt[k] ? 32'h0 : 32'h3);
      prevStall = stallAt[k];
      if (stallAt[k]) held++;
      prevIfId = expIfId;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) prog[i] = 32'h0;
    // Sweep: R2 R6 R8 over load/ALU producer, dest 0..3, sources 0..3
    for (int isLoad = 0; isLoad < 2; isLoad++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          for (int c = 0; c < 4; c++) begin
            bit s;
            for (int i = 0; i < 8; i++) prog[i] = 32'h0;
            prog[0] = isLoad ? mkLoad(7, a) : mkAlu(7, a);
            prog[1] = mkAlu(b, c);
            prog[2] = mkAlu(1, 2);
            s = (isLoad == 1) && (a != 0) && (a == b || a == c);
            runCase(isLoad ? "R2/R6 load" : "R6 alu", (NEDGE + 1)'(s) << 2);
          end
    // R8: load followed by independent load, then its non-user
    for (int i = 0; i < 8; i++) prog[i] = 32'h0;
    prog[0] = mkLoad(2, 1);
    prog[1] = mkLoad(3, 4);
    prog[2] = mkAlu(5, 6);
    runCase("R8 back-to-back loads", '0);
    // R5: chained load -> dependent load -> user, one stall per pair
    for (int i = 0; i < 8; i++) prog[i] = 32'h0;
    prog[0] = mkLoad(2, 1);
    prog[1] = mkLoad(1, 3);
    prog[2] = mkAlu(3, 4);
    runCase("R5 chain", 7'b0010100);
    // R5: load then user through second source field only
    for (int i = 0; i < 8; i++) prog[i] = 32'h0;
    prog[0] = mkLoad(2, 17);
    prog[1] = mkAlu(5, 17);
    prog[2] = mkAlu(17, 17);
    runCase("R5 rt-field use", 7'b0000100);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule